// File: doc/BRIEF.md
# Indirect cross-chip VLAN table

This block holds one port-mask word per (source device, source port) pair. Forwarding logic uses the mask to decide which local ports a frame from that remote source may reach. Software reaches the table through two registers on a 16-bit register bus. The first is a data register that carries the operand or the result. The second is a command register that carries a busy flag, an operation code and a 9-bit entry pointer.

To store a mask, software first waits until busy is clear. It then loads the data register and writes the command register with busy set and the write code. The block performs the access and drops busy two cycles later. A read command works the same way, and it leaves the addressed entry in the data register.

A separate lookup port takes a source device and a source port and returns the matching mask one cycle later. After reset, every entry permits all ports.

Top module: `xchip_vlan_tbl`

## Requirements
- R1: After reset every table entry is 16'hFFFF, the data register reads 0 and the command register reads 0 (busy clear).
- R2: The entry pointer is the low 9 bits of the command word, with the source device in bits 8:4 and the source port in bits 3:0. The lookup port addresses the same entry from `lkp_dev_i` and `lkp_port_i`.
- R3: A command-register write with bit 15 set, made while idle, starts an operation. Bit 15 then reads 1 for exactly two cycles after that write edge and 0 from the third edge on.
- R4: Operation code 3'b011 (command bits 14:12) copies the data register into the addressed entry.
- R5: Operation code 3'b100 loads the addressed entry into the data register, and the new value is readable while busy is still set (one cycle after the command edge).
- R6: Any other operation code completes in the same two cycles and changes neither the table nor the data register.
- R7: Command-register writes made while busy is set are ignored. The stored code and pointer stay the same, and no second operation starts.
- R8: Data-register writes made while busy is set are ignored.
- R9: A command-register write with bit 15 clear stores the code and pointer but does not start an operation. Busy stays 0 and the table is unchanged.
- R10: `lkp_mask_o` shows the entry selected by the lookup inputs one clock edge after they are applied, including writes that completed before that edge.
- R11: The command register reads back as {busy, code[2:0], 3'b000, pointer[8:0]}. Register select 0 is the data register and select 1 is the command register; bus reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_sel_i | input | 1 | Register select: 0 data, 1 command |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| lkp_dev_i | input | 5 | Lookup source device |
| lkp_port_i | input | 4 | Lookup source port |
| lkp_mask_o | output | 16 | Port mask of the looked-up entry |

## Verification
A command written at edge N shows busy after edges N and N+1 and clears at N+2. A read result appears in the data register after edge N+1, and a lookup answers one edge after its inputs change. The bench drives every input on the falling edge and reads back at the next falling edge. It counts one edge per register in each path, so busy and the read data are checked inside that two-cycle window, and lookups are checked exactly one cycle after the inputs are applied. Writes issued inside the busy window, and commands with the start bit clear, are each followed by readback of the command register, the data register and the lookup port before any further stimulus.

// File: rtl/xvt_pkg.sv
package xvt_pkg;
  localparam int unsigned BUS_W    = 16;
  localparam int unsigned GO_BIT   = 15;
  localparam int unsigned OP_HI    = 14;
  localparam int unsigned OP_LO    = 12;
  localparam logic [2:0]  OP_STORE = 3'b011;
  localparam logic [2:0]  OP_FETCH = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;
endpackage

// File: rtl/xvt_regif.sv
module xvt_regif
  import xvt_pkg::*;
#(
  parameter int unsigned PTR_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             busy_i,
  input  logic             rd_load_i,
  input  logic [BUS_W-1:0] rd_data_i,
  output logic             start_o,
  output logic [2:0]       op_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [BUS_W-1:0] data_o
);
  logic             cmd_wr, data_wr;
  logic [2:0]       op_q;
  logic [PTR_W-1:0] ptr_q;
  logic [BUS_W-1:0] data_q;
  logic [BUS_W-1:0] cmd_word;
  logic             unused_wbits;

  assign cmd_wr  = wr_i && sel_i && !busy_i;
  assign data_wr = wr_i && !sel_i && !busy_i;
  assign start_o = cmd_wr && wdata_i[GO_BIT];
  assign unused_wbits = ^wdata_i[OP_LO-1:PTR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= '0;
      ptr_q <= '0;
    end else if (cmd_wr) begin
      op_q  <= wdata_i[OP_HI:OP_LO];
      ptr_q <= wdata_i[PTR_W-1:0];
    end
  end

  // fetch result wins; bus writes are locked out while busy anyway
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (rd_load_i) data_q <= rd_data_i;
    else if (data_wr)   data_q <= wdata_i;
  end

  always_comb begin
    cmd_word              = '0;
    cmd_word[GO_BIT]      = busy_i;
    cmd_word[OP_HI:OP_LO] = op_q;
    cmd_word[PTR_W-1:0]   = ptr_q;
  end

  assign rdata_o = sel_i ? cmd_word : data_q;
  assign op_o    = op_q;
  assign ptr_o   = ptr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/xvt_seq.sv
module xvt_seq
  import xvt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] op_i,
  output logic       busy_o,
  output logic       exec_o,
  output logic       tbl_we_o,
  output logic       rd_load_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_EXEC;
      ST_EXEC: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign exec_o    = (st_q == ST_EXEC);
  assign tbl_we_o  = exec_o && (op_i == OP_STORE);
  assign rd_load_o = exec_o && (op_i == OP_FETCH);
endmodule

// File: rtl/xvt_store.sv
module xvt_store #(
  parameter int unsigned PTR_W   = 9,
  parameter int unsigned DATA_W  = 16,
  parameter bit          LKP_REG = 1'b1,
  localparam int unsigned DEPTH  = 1 << PTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  acc_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [PTR_W-1:0]  lkp_addr_i,
  output logic [DATA_W-1:0] lkp_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // reset opens every entry to all ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[acc_addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[acc_addr_i];

  if (LKP_REG) begin : g_lkp_reg
    logic [DATA_W-1:0] lkp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lkp_q <= '1;
      else         lkp_q <= mem_q[lkp_addr_i];
    end
    assign lkp_o = lkp_q;
  end else begin : g_lkp_comb
    assign lkp_o = mem_q[lkp_addr_i];
  end
endmodule

// File: rtl/xchip_vlan_tbl.sv
module xchip_vlan_tbl
  import xvt_pkg::*;
#(
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned PORT_W = 4,
  localparam int unsigned PTR_W = DEV_W + PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  input  logic [DEV_W-1:0]  lkp_dev_i,
  input  logic [PORT_W-1:0] lkp_port_i,
  output logic [BUS_W-1:0]  lkp_mask_o
);
  logic             busy, exec, start, tbl_we, rd_load;
  logic [2:0]       op;
  logic [PTR_W-1:0] ptr;
  logic [BUS_W-1:0] data, tbl_rdata;

  xvt_regif #(.PTR_W(PTR_W)) u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (reg_sel_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .rd_load_i (rd_load),
    .rd_data_i (tbl_rdata),
    .start_o   (start),
    .op_o      (op),
    .ptr_o     (ptr),
    .data_o    (data)
  );

  xvt_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .op_i      (op),
    .busy_o    (busy),
    .exec_o    (exec),
    .tbl_we_o  (tbl_we),
    .rd_load_o (rd_load)
  );

  xvt_store #(.PTR_W(PTR_W), .DATA_W(BUS_W), .LKP_REG(1'b1)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we),
    .acc_addr_i (ptr),
    .wdata_i    (data),
    .rdata_o    (tbl_rdata),
    .lkp_addr_i ({lkp_dev_i, lkp_port_i}),
    .lkp_o      (lkp_mask_o)
  );
endmodule

// File: rtl/xvt_chk.sv
module xvt_chk #(
  parameter int unsigned PTR_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             exec_i,
  input logic             cmd_wr_i,
  input logic             go_i,
  input logic             data_wr_i,
  input logic [2:0]       op_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic [15:0]      data_i
);
  a_r3_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |=> busy_i);

  a_r3_busy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |=> ##1 !busy_i);

  a_r7_cmd_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cmd_wr_i) |=> ($stable(op_i) && $stable(ptr_i)));

  a_r8_data_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !exec_i && data_wr_i) |=> $stable(data_i));

  a_r9_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && cmd_wr_i && !go_i) |=> !busy_i);
endmodule

bind xchip_vlan_tbl xvt_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy),
  .exec_i    (exec),
  .cmd_wr_i  (reg_wr_i && reg_sel_i),
  .go_i      (reg_wdata_i[15]),
  .data_wr_i (reg_wr_i && !reg_sel_i),
  .op_i      (op),
  .ptr_i     (ptr),
  .data_i    (data)
);

// File: tb/sim_xchip_vlan_tbl.sv
`timescale 1ns/1ps
module sim_xchip_vlan_tbl;
  localparam logic [2:0] OPW = 3'b011;
  localparam logic [2:0] OPR = 3'b100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, lkp;
  logic [4:0]  dev = '0;
  logic [3:0]  port = '0;

  int n_chk = 0, n_err = 0;
  logic [15:0] exp_mem [512];
  logic [15:0] exp_data;

  always #10 clk = ~clk;

  xchip_vlan_tbl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lkp_dev_i(dev),
    .lkp_port_i(port), .lkp_mask_o(lkp)
  );

  function automatic logic [15:0] mk_cmd(bit go, logic [2:0] op, logic [8:0] p);
    return {go, op, 3'b000, p};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bw(bit s, logic [15:0] v);
    @(negedge clk); sel = s; wr = 1'b1; wdata = v;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd(bit s, output logic [15:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic do_op(logic [2:0] op, logic [8:0] p, logic [15:0] d);
    logic [15:0] v;
    bw(1'b0, d);
    bw(1'b1, mk_cmd(1'b1, op, p));
    rd(1'b1, v); check("R3/R11 busy after command", v, mk_cmd(1'b1, op, p));
    @(negedge clk);
    rd(1'b1, v); check("R3 busy second cycle", v[15], 1'b1);
    if (op == OPR) begin
      rd(1'b0, v); check("R5 fetch visible while busy", v, exp_mem[p]);
    end
    @(negedge clk);
    rd(1'b1, v); check("R3 busy cleared", v[15], 1'b0);
    if (op == OPW) begin exp_mem[p] = d; exp_data = d; end
    else if (op == OPR) exp_data = exp_mem[p];
    else exp_data = d;
    rd(1'b0, v); check("R4/R5/R6 data register", v, exp_data);
  endtask

  task automatic look(logic [8:0] p, string req);
    @(negedge clk); dev = p[8:4]; port = p[3:0];
    @(negedge clk); check(req, lkp, exp_mem[p]);
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < 512; i++) exp_mem[i] = 16'hFFFF;
    exp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, v); check("R1 data reset", v, 16'h0000);
    rd(1'b1, v); check("R1 cmd reset", v, 16'h0000);
    look(9'd0, "R1 entry 0 open");
    look(9'd511, "R1 entry 511 open");

    // R2 field layout: device 0x15 port 0xA -> pointer 0x15A
    do_op(OPW, {5'h15, 4'hA}, 16'h0F0F);
    look({5'h15, 4'hA}, "R2 lookup by device/port");
    look({5'h15, 4'hB}, "R2 neighbour untouched");
    look({5'h14, 4'hA}, "R10 lookup one cycle");

    // R4 boundaries
    do_op(OPW, 9'd0, 16'h0000);
    do_op(OPW, 9'd511, 16'h8001);
    look(9'd0, "R4 entry 0 stored");
    look(9'd511, "R4 entry 511 stored");
    do_op(OPR, 9'd511, 16'h1234);
    do_op(OPR, 9'd300, 16'h0000);

    // R6 unused codes
    do_op(3'b000, 9'd7, 16'h5A5A);
    do_op(3'b111, 9'd7, 16'h3C3C);
    look(9'd7, "R6 table unchanged");

    // R7 command during busy ignored
    bw(1'b0, 16'h1234);
    bw(1'b1, mk_cmd(1'b1, OPW, 9'd40));
    bw(1'b1, mk_cmd(1'b1, OPW, 9'd41));
    exp_mem[40] = 16'h1234;
    rd(1'b1, v); check("R7 cmd kept", v, mk_cmd(1'b0, OPW, 9'd40));
    look(9'd41, "R7 no second write");
    look(9'd40, "R7 first write done");

    // R8 data write during busy ignored
    bw(1'b0, 16'hAAAA);
    bw(1'b1, mk_cmd(1'b1, OPR, 9'd40));
    bw(1'b0, 16'h5555);
    rd(1'b0, v); check("R8 data write ignored", v, 16'h1234);

    // R9 command without go bit
    bw(1'b0, 16'h0001);
    bw(1'b1, mk_cmd(1'b0, OPW, 9'd99));
    rd(1'b1, v); check("R9 no start, R11 fields", v, mk_cmd(1'b0, OPW, 9'd99));
    @(negedge clk);
    rd(1'b1, v); check("R9 still idle", v[15], 1'b0);
    look(9'd99, "R9 table unchanged");

    // random traffic
    for (int i = 0; i < 300; i++) begin
      int unsigned k;
      logic [8:0]  p;
      logic [15:0] d;
      k = $urandom % 4;
      p = 9'($urandom);
      d = 16'($urandom);
      case (k)
        0: do_op(OPW, p, d);
        1: do_op(OPR, p, d);
        2: do_op(3'($urandom) | 3'b000, p, d);
        default: look(p, "R10 random lookup");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule